// File: doc/BRIEF.md
# Logical Device Activation and I/O Range-Check Responder

This block is the per-function control slice of a plug-and-play card. It keeps three kinds of configuration state for one logical device: an enable bit that puts the device on the host I/O bus, a range-check register used for conflict probing, and a set of 16-bit I/O base addresses. All of this state is written and read back through the card's configuration index/data path. Each access applies only when the card-wide logical-device number matches this slice's own number.

On the host side, the block compares every I/O address with the programmed bases. Each base opens a window of a fixed number of bytes, and a base of zero turns its window off. When the device is enabled, a hit raises the normal decode output for reads and writes. When the device is disabled and range check is armed, a read that hits a window is answered with a fixed byte pattern instead. Software can then look for address conflicts before it turns the device on. A device-level clear command returns all of the state to zero.

Top module: `ldev_io_responder`

## Requirements
- R1: After reset the enable bit, the range-check bits and every base read back as 0x00, and neither decode nor test drive is asserted for any address.
- R2: Index 0x30 holds the enable bit in bit 0. A selected write stores wdata[0]. Readback returns {7'b0, enable}.
- R3: Index 0x31 holds two bits. Bit 1 arms range check and bit 0 picks the test byte. Readback returns {6'b0, arm, pick}.
- R4: Base n (n = 0 to NUM_RANGES-1) uses index 0x60+2n for address bits [15:8] and index 0x61+2n for bits [7:0]. Both bytes read back as they were written.
- R5: A configuration write while cfg_ldn differs from LDN_ID changes no state. Reads while it differs return 0x00. Indices that are not mapped read 0x00 and ignore writes.
- R6: An address hits range n when base n is nonzero and base n <= address < base n + RANGE_BYTES. A zero base never hits.
- R7: io_dec is high only when the device is enabled, io_rd or io_wr is high, and the address hits some range.
- R8: While the device is disabled and range check is armed, a read (io_rd) that hits drives io_test_drive high. io_test_data is 0x55 when the pick bit is 1 and 0xAA when it is 0. A write never causes a test drive.
- R9: While the device is enabled, range check has no effect. No test drive occurs and io_test_data stays 0x00.
- R10: A dev_clr pulse zeroes the enable bit, the range-check bits and all bases on the next clock edge. It takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ldn | input | 8 | Currently selected logical-device number |
| cfg_idx | input | 8 | Configuration register index |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| dev_clr | input | 1 | Device-level clear command |
| io_addr | input | 16 | Host I/O address |
| io_rd | input | 1 | Host I/O read strobe |
| io_wr | input | 1 | Host I/O write strobe |
| io_dec | output | 1 | Normal decode hit while enabled |
| io_test_drive | output | 1 | Drive the test byte onto the read data |
| io_test_data | output | 8 | Test byte, 0x00 when not driving |

## Verification
The bench builds the block with LDN_ID = 3, eight ranges and an 8-byte window. With this setup it can program the last base slot at index 0x6E/0x6F and probe the first and last byte of a window, as well as the bytes just outside it. Using a nonzero device number lets a write with a mismatched number show that the selection gate works. Keeping one slot at a zero base checks that address zero stays unclaimed.

// File: rtl/ldev_pkg.sv
package ldev_pkg;
   localparam logic [7:0] IDX_ACT   = 8'h30;
   localparam logic [7:0] IDX_CHK   = 8'h31;
   localparam logic [7:0] IDX_IO    = 8'h60;
   localparam logic [7:0] PAT_ONE   = 8'h55;
   localparam logic [7:0] PAT_ZERO  = 8'hAA;
   localparam int         IO_AW     = 16;

   typedef struct packed {
      logic arm;
      logic pick;
   } chk_t;
endpackage

// File: rtl/ldev_cfg_regs.sv
module ldev_cfg_regs
   import ldev_pkg::*;
#(
   parameter int NUM_RANGES = 8
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                sel,
   input  logic [7:0]                          idx,
   input  logic                                wr,
   input  logic [7:0]                          wdata,
   input  logic                                clr,
   output logic [7:0]                          rdata,
   output logic                                act_q,
   output chk_t                                chk_q,
   output logic [NUM_RANGES-1:0][IO_AW-1:0]    base_q
);
   logic wr_en;
   assign wr_en = wr & sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         chk_q <= '0;
      end else if (clr) begin
         act_q <= 1'b0;
         chk_q <= '0;
      end else if (wr_en) begin
         if (idx == IDX_ACT) act_q <= wdata[0];
         if (idx == IDX_CHK) chk_q <= '{arm: wdata[1], pick: wdata[0]};
      end
   end

   for (genvar g = 0; g < NUM_RANGES; g++) begin : g_base
      localparam logic [7:0] HI_IDX = IDX_IO + 8'(2 * g);
      localparam logic [7:0] LO_IDX = IDX_IO + 8'(2 * g + 1);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q[g] <= '0;
         end else if (clr) begin
            base_q[g] <= '0;
         end else if (wr_en) begin
            if (idx == HI_IDX) base_q[g][15:8] <= wdata;
            if (idx == LO_IDX) base_q[g][7:0]  <= wdata;
         end
      end
   end

   always_comb begin
      rdata = 8'h00;
      if (sel) begin
         if (idx == IDX_ACT) rdata = {7'b0, act_q};
         if (idx == IDX_CHK) rdata = {6'b0, chk_q.arm, chk_q.pick};
         for (int i = 0; i < NUM_RANGES; i++) begin
            if (idx == IDX_IO + 8'(2 * i))     rdata = base_q[i][15:8];
            if (idx == IDX_IO + 8'(2 * i + 1)) rdata = base_q[i][7:0];
         end
      end
   end

   // R2
   act_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && idx == IDX_ACT && !clr) |=> (act_q == $past(wdata[0])));

   // R5
   unsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !sel && !clr) |=> (act_q == $past(act_q) && chk_q == $past(chk_q)
                                && base_q == $past(base_q)));

   // R10
   clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!act_q && chk_q == '0 && base_q == '0));
endmodule

// File: rtl/ldev_range_match.sv
module ldev_range_match
   import ldev_pkg::*;
#(
   parameter int NUM_RANGES  = 8,
   parameter int RANGE_BYTES = 8
) (
   input  logic [NUM_RANGES-1:0][IO_AW-1:0] base,
   input  logic [IO_AW-1:0]                 addr,
   output logic [NUM_RANGES-1:0]            hit_vec,
   output logic                             hit
);
   localparam logic [IO_AW:0] SPAN = (IO_AW+1)'(RANGE_BYTES);

   for (genvar g = 0; g < NUM_RANGES; g++) begin : g_cmp
      logic [IO_AW:0] lo, hi_excl, a;
      assign lo      = {1'b0, base[g]};
      assign hi_excl = lo + SPAN;
      assign a       = {1'b0, addr};
      assign hit_vec[g] = (base[g] != '0) && (a >= lo) && (a < hi_excl);
   end

   assign hit = |hit_vec;
endmodule

// File: rtl/ldev_resp_mux.sv
module ldev_resp_mux
   import ldev_pkg::*;
(
   input  logic       hit,
   input  logic       act,
   input  chk_t       chk,
   input  logic       rd,
   input  logic       wr,
   output logic       dec,
   output logic       drive,
   output logic [7:0] data
);
   always_comb begin
      dec   = act & hit & (rd | wr);
      drive = ~act & chk.arm & hit & rd;
      data  = 8'h00;
      if (drive) data = chk.pick ? PAT_ONE : PAT_ZERO;
   end
endmodule

// File: rtl/ldev_io_responder.sv
module ldev_io_responder
   import ldev_pkg::*;
#(
   parameter int          NUM_RANGES  = 8,
   parameter int          RANGE_BYTES = 8,
   parameter logic [7:0]  LDN_ID      = 8'd0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [7:0]  cfg_ldn,
   input  logic [7:0]  cfg_idx,
   input  logic        cfg_wr,
   input  logic [7:0]  cfg_wdata,
   output logic [7:0]  cfg_rdata,
   input  logic        dev_clr,
   input  logic [15:0] io_addr,
   input  logic        io_rd,
   input  logic        io_wr,
   output logic        io_dec,
   output logic        io_test_drive,
   output logic [7:0]  io_test_data
);
   if (NUM_RANGES < 1 || NUM_RANGES > 8) begin : g_bad_n
      $error("NUM_RANGES must be 1..8");
   end
   if (RANGE_BYTES < 1 || RANGE_BYTES > 256) begin : g_bad_span
      $error("RANGE_BYTES must be 1..256");
   end

   logic                             sel;
   logic                             act;
   chk_t                             chk;
   logic [NUM_RANGES-1:0][IO_AW-1:0] base;
   logic [NUM_RANGES-1:0]            hit_vec;
   logic                             hit;

   assign sel = (cfg_ldn == LDN_ID);

   ldev_cfg_regs #(.NUM_RANGES(NUM_RANGES)) u_regs (
      .clk(clk), .rst_n(rst_n), .sel(sel), .idx(cfg_idx), .wr(cfg_wr),
      .wdata(cfg_wdata), .clr(dev_clr), .rdata(cfg_rdata),
      .act_q(act), .chk_q(chk), .base_q(base)
   );

   ldev_range_match #(.NUM_RANGES(NUM_RANGES), .RANGE_BYTES(RANGE_BYTES)) u_match (
      .base(base), .addr(io_addr), .hit_vec(hit_vec), .hit(hit)
   );

   ldev_resp_mux u_resp (
      .hit(hit), .act(act), .chk(chk), .rd(io_rd), .wr(io_wr),
      .dec(io_dec), .drive(io_test_drive), .data(io_test_data)
   );

   // R7
   dec_needs_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
      io_dec |-> (act && hit));

   // R9
   drive_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      io_test_drive |-> (!act && !io_dec));

   // R8
   pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
      io_test_drive |-> (io_test_data == PAT_ONE || io_test_data == PAT_ZERO));

   // R6
   zero_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (base == '0) |-> !hit);
endmodule

// File: tb/ldev_io_responder_test.sv
`timescale 1ns/1ps
module ldev_io_responder_test;
   localparam logic [7:0] MY_LDN = 8'd3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  cfg_ldn = '0, cfg_idx = '0, cfg_wdata = '0;
   logic        cfg_wr = 1'b0, dev_clr = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_rd = 1'b0, io_wr = 1'b0;
   logic [7:0]  cfg_rdata, io_test_data;
   logic        io_dec, io_test_drive;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   ldev_io_responder #(.NUM_RANGES(8), .RANGE_BYTES(8), .LDN_ID(MY_LDN)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_ldn(cfg_ldn), .cfg_idx(cfg_idx),
      .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .dev_clr(dev_clr), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
      .io_dec(io_dec), .io_test_drive(io_test_drive), .io_test_data(io_test_data)
   );

   // {addr[15:0], rd, wr, dec, drive, data[7:0]}: disabled, armed, pick=1
   localparam int NV = 8;
   localparam logic [27:0] VEC [NV] = '{
      {16'h0220, 1'b1, 1'b0, 1'b0, 1'b1, 8'h55},  // R8 first byte
      {16'h0227, 1'b1, 1'b0, 1'b0, 1'b1, 8'h55},  // R6 last byte
      {16'h0228, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},  // R6 past end
      {16'h021F, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},  // R6 below base
      {16'h0220, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00},  // R8 write no drive
      {16'h0FFF, 1'b1, 1'b0, 1'b0, 1'b1, 8'h55},  // R4 last slot
      {16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},  // R6 zero base
      {16'h0003, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00}   // R6 zero base
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [7:0] ldn, input logic [7:0] idx, input logic [7:0] val);
      @(negedge clk);
      cfg_ldn = ldn; cfg_idx = idx; cfg_wdata = val; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic cfg_read(input string req, input logic [7:0] ldn, input logic [7:0] idx,
                           input logic [7:0] exp);
      @(negedge clk);
      cfg_ldn = ldn; cfg_idx = idx;
      #1;
      chk(req, {8'h0, cfg_rdata}, {8'h0, exp});
   endtask

   task automatic io_try(input string req, input logic [15:0] a, input logic rd, input logic wr,
                         input logic dec, input logic drv, input logic [7:0] dat);
      @(negedge clk);
      io_addr = a; io_rd = rd; io_wr = wr;
      #1;
      chk(req, {io_dec, io_test_drive, 6'b0, io_test_data}, {dec, drv, 6'b0, dat});
      io_rd = 1'b0; io_wr = 1'b0;
   endtask

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      cfg_read("R1", MY_LDN, 8'h30, 8'h00);
      cfg_read("R1", MY_LDN, 8'h31, 8'h00);
      cfg_read("R1", MY_LDN, 8'h60, 8'h00);
      io_try("R1", 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);

      // R4 program bases: slot0 0x0220, slot7 0x0FF8, slot2 left 0
      cfg_write(MY_LDN, 8'h60, 8'h02);
      cfg_write(MY_LDN, 8'h61, 8'h20);
      cfg_write(MY_LDN, 8'h6E, 8'h0F);
      cfg_write(MY_LDN, 8'h6F, 8'hF8);
      cfg_read("R4", MY_LDN, 8'h60, 8'h02);
      cfg_read("R4", MY_LDN, 8'h61, 8'h20);
      cfg_read("R4", MY_LDN, 8'h6E, 8'h0F);
      cfg_read("R4", MY_LDN, 8'h6F, 8'hF8);
      cfg_read("R4", MY_LDN, 8'h64, 8'h00);

      // R3 arm + pick=1, upper bits written 1 read back zero
      cfg_write(MY_LDN, 8'h31, 8'hFF);
      cfg_read("R3", MY_LDN, 8'h31, 8'h03);

      for (int i = 0; i < NV; i++) begin
         io_try("R6/R8 vec", VEC[i][27:12], VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:0]);
      end

      // R8 pick=0 gives 0xAA
      cfg_write(MY_LDN, 8'h31, 8'h02);
      io_try("R8", 16'h0224, 1'b1, 1'b0, 1'b0, 1'b1, 8'hAA);
      // R8 disarmed: nothing
      cfg_write(MY_LDN, 8'h31, 8'h01);
      io_try("R8", 16'h0224, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
      cfg_write(MY_LDN, 8'h31, 8'h03);

      // R2 enable, upper bits read zero
      cfg_write(MY_LDN, 8'h30, 8'hFF);
      cfg_read("R2", MY_LDN, 8'h30, 8'h01);
      // R9 / R7 active: decode, no test drive even though armed
      io_try("R9", 16'h0220, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
      io_try("R7", 16'h0FFA, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00);
      io_try("R7", 16'h0228, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
      io_try("R7", 16'h0220, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);

      // R5 unselected write ignored, unselected read zero, unmapped index
      cfg_write(8'd4, 8'h30, 8'h00);
      cfg_write(8'd4, 8'h61, 8'h99);
      cfg_read("R5", MY_LDN, 8'h30, 8'h01);
      cfg_read("R5", MY_LDN, 8'h61, 8'h20);
      cfg_read("R5", 8'd4, 8'h30, 8'h00);
      cfg_write(MY_LDN, 8'h40, 8'h77);
      cfg_read("R5", MY_LDN, 8'h40, 8'h00);
      io_try("R5", 16'h0221, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00);

      // R2 disable again
      cfg_write(MY_LDN, 8'h30, 8'h00);
      cfg_read("R2", MY_LDN, 8'h30, 8'h00);

      // R10 clear beats simultaneous write
      @(negedge clk);
      dev_clr = 1'b1; cfg_ldn = MY_LDN; cfg_idx = 8'h30; cfg_wdata = 8'h01; cfg_wr = 1'b1;
      @(negedge clk);
      dev_clr = 1'b0; cfg_wr = 1'b0;
      cfg_read("R10", MY_LDN, 8'h30, 8'h00);
      cfg_read("R10", MY_LDN, 8'h31, 8'h00);
      cfg_read("R10", MY_LDN, 8'h60, 8'h00);
      cfg_read("R10", MY_LDN, 8'h6F, 8'h00);
      io_try("R10", 16'h0220, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule